// File: doc/BRIEF.md
# PCI Express Endpoint Interrupt Generator

This block is the interrupt front end of a PCI Express endpoint. It turns application interrupt activity into one of two outbound forms. The first is a pair of legacy wire-interrupt events, assert and deassert. The second is a Message Signaled Interrupt, carried as a posted memory write with a single data dword. Which form is used depends on configuration bits that software programs. The legacy path and the MSI path never both signal at once, and MSI wins whenever its enable is set.

A legacy source is a level input. Each change in its effective level, after mode and masking are applied, gives a one-cycle assert or deassert event. An MSI source raises a request together with a traffic class and a vector number, and holds the request until the block acknowledges it. In MSI mode the block latches a complete TLP header and data dword when it accepts the request. It presents them on a valid/ready channel and pulses the acknowledge once the channel accepts them. If MSI is off, the request is acknowledged and nothing is sent.

Top module: `pcie_irq_gen`

## Requirements
- R1: After reset, tx_valid, irq_ack, leg_assert_msg and leg_deassert_msg are all low.
- R2: With cfg_msi_on and cfg_legacy_mask low, a rise of leg_irq gives a one-cycle leg_assert_msg pulse in the following cycle, and a fall gives a one-cycle leg_deassert_msg pulse in the same way. The two pulses are never high together.
- R3: While cfg_legacy_mask is set, leg_irq produces no assert pulse. Setting the mask while the effective level is high produces a deassert pulse, and clearing it while leg_irq is high produces an assert pulse.
- R4: While cfg_msi_on is set, no legacy assert pulse is produced, whatever the value of cfg_legacy_mask. Setting cfg_msi_on while the legacy level is active produces a deassert pulse.
- R5: In MSI mode an accepted request makes tx_valid rise in the next cycle. tx_valid stays high, with tx_hdr and tx_data unchanged, until tx_ready is seen, and exactly one TLP is presented per request.
- R6: Header dword 0 sits in tx_hdr[31:0] and holds fmt in bits 31:29, type in 28:24, TC in 22:20 and length in 9:0. The type is 0 and the length is 1. The fmt is 3'b010 (three-dword header) when cfg_msi_ctrl[7] is 0 and 3'b011 (four-dword header) when it is 1. Dword 1 sits in tx_hdr[63:32] and holds cfg_bdf in bits 31:16, tag 0, last byte enable 0 and first byte enable 4'hF. For a three-dword header, dword 2 is the address with bits 1:0 cleared and dword 3 is 0. For a four-dword header, dword 2 is address bits 63:32 and dword 3 is the low address with bits 1:0 cleared.
- R7: tx_data is cfg_msi_msgdata zero-extended to 32 bits. Its low n bits are replaced by the low n bits of irq_vec, where n is cfg_msi_ctrl[6:4] limited to the vector width of 5. Vector bits at and above n are masked to zero.
- R8: irq_ack is a one-cycle pulse in the cycle after the tx_valid/tx_ready handshake. A held request is not accepted again while its TLP is pending.
- R9: A request made while cfg_msi_on is low is acknowledged in the next cycle, and tx_valid stays low.
- R10: The traffic class and vector are taken from the inputs in the cycle the request is accepted. Later changes to irq_tc or irq_vec do not alter the pending TLP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_msi_on | input | 1 | MSI enable from configuration |
| cfg_legacy_mask | input | 1 | Command register Interrupt Disable bit |
| cfg_msi_ctrl | input | 16 | MSI control field; bit 7 is 64-bit capable, bits 6:4 give the enabled vector count |
| cfg_msi_addr | input | 64 | MSI target address |
| cfg_msi_msgdata | input | 16 | MSI message data |
| cfg_bdf | input | 16 | Requester ID placed in the header |
| leg_irq | input | 1 | Legacy interrupt level from the application |
| leg_assert_msg | output | 1 | One-cycle legacy assert event |
| leg_deassert_msg | output | 1 | One-cycle legacy deassert event |
| irq_req | input | 1 | MSI request, held until irq_ack |
| irq_tc | input | 3 | Traffic class for the MSI |
| irq_vec | input | 5 | Vector number for the MSI |
| irq_ack | output | 1 | One-cycle acknowledge of a request |
| tx_valid | output | 1 | TLP header and data valid |
| tx_ready | input | 1 | Downstream accepts the TLP |
| tx_hdr | output | 128 | TLP header, dword 0 in the low bits |
| tx_data | output | 32 | TLP data dword |

## Verification
A wrong legacy level register shows one cycle after the input change: a missing, doubled or wrong-polarity event pulse. A stuck request state shows as tx_valid staying high after the acknowledge. A dropped request shows as no acknowledge in the cycle after the handshake, and a state that re-accepts a held request shows as a second tx_valid window. A wrong field latch shows in the first cycle tx_valid is high, as a header or data word that differs from the value computed from the inputs. A wrong latch enable shows as a header that follows irq_tc or irq_vec while the TLP is held back.

// File: rtl/irq_gen_pkg.sv
package irq_gen_pkg;
    localparam int DW_W     = 32;
    localparam int HDR_DWS  = 4;
    localparam int HDR_W    = HDR_DWS * DW_W;
    localparam int CTL_W    = 16;
    localparam int A64_BIT  = 7;
    localparam int MME_LO   = 4;
    localparam int MME_W    = 3;

    localparam logic [2:0] FMT_3DW_DATA = 3'b010;
    localparam logic [2:0] FMT_4DW_DATA = 3'b011;
    localparam logic [4:0] TYPE_MEM     = 5'b00000;
    localparam logic [3:0] BE_FULL      = 4'hF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_DONE = 2'd2
    } ctrl_st_e;

    typedef struct packed {
        logic lvl;
        logic asrt;
        logic deasrt;
    } leg_t;

    typedef struct packed {
        ctrl_st_e           st;
        logic [HDR_W-1:0]   hdr;
        logic [DW_W-1:0]    data;
    } ctrl_t;
endpackage

// File: rtl/irq_legacy_track.sv
module irq_legacy_track
    import irq_gen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic msi_on,
    input  logic legacy_mask,
    input  logic lvl_in,
    output logic asrt_o,
    output logic deasrt_o
);
    leg_t q, d;
    logic eff;

    always_comb begin
        eff      = lvl_in && !msi_on && !legacy_mask;
        d.lvl    = eff;
        d.asrt   = eff && !q.lvl;
        d.deasrt = !eff && q.lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign asrt_o   = q.asrt;
    assign deasrt_o = q.deasrt;

    assert_pulse_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(asrt_o && deasrt_o));
    assert_mask_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(legacy_mask) |-> !asrt_o);
    assert_msi_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(msi_on) |-> !asrt_o);
endmodule

// File: rtl/irq_msi_fmt.sv
module irq_msi_fmt
    import irq_gen_pkg::*;
#(
    parameter int TC_W   = 3,
    parameter int VEC_W  = 5,
    parameter int MSG_W  = 16,
    parameter int RID_W  = 16,
    parameter int ADDR_W = 64
) (
    input  logic [CTL_W-1:0]  ctl,
    input  logic [ADDR_W-1:0] addr,
    input  logic [MSG_W-1:0]  msg,
    input  logic [RID_W-1:0]  rid,
    input  logic [TC_W-1:0]   tc,
    input  logic [VEC_W-1:0]  vec,
    output logic [HDR_W-1:0]  hdr,
    output logic [DW_W-1:0]   data
);
    localparam int PAD_W = MSG_W - VEC_W;

    logic [MME_W-1:0] mme;
    logic [VEC_W-1:0] vmask;
    logic [MSG_W-1:0] merged;
    logic [DW_W-1:0]  dw0, dw1, dw2, dw3, lo_addr;
    logic             wide;
    logic             unused_bits;

    assign mme  = ctl[MME_LO +: MME_W];
    assign wide = ctl[A64_BIT];
    assign unused_bits = ^{ctl[CTL_W-1:A64_BIT+1], ctl[MME_LO-1:0], addr[1:0]};

    for (genvar i = 0; i < VEC_W; i++) begin : g_mask
        assign vmask[i] = (mme > MME_W'(i));
    end

    always_comb begin
        merged  = (msg & ~{{PAD_W{1'b0}}, vmask}) | {{PAD_W{1'b0}}, vec & vmask};
        data    = {{(DW_W-MSG_W){1'b0}}, merged};
        lo_addr = {addr[31:2], 2'b00};
        dw0     = '0;
        dw0[31:29] = wide ? FMT_4DW_DATA : FMT_3DW_DATA;
        dw0[28:24] = TYPE_MEM;
        dw0[20 +: TC_W] = tc;
        dw0[9:0]   = 10'd1;
        dw1        = {rid, 8'h00, 4'h0, BE_FULL};
        if (wide) begin
            dw2 = addr[ADDR_W-1:32];
            dw3 = lo_addr;
        end else begin
            dw2 = lo_addr;
            dw3 = '0;
        end
        hdr = {dw3, dw2, dw1, dw0};
    end
endmodule

// File: rtl/irq_msi_ctrl.sv
module irq_msi_ctrl
    import irq_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msi_on,
    input  logic             req,
    input  logic [HDR_W-1:0] hdr_in,
    input  logic [DW_W-1:0]  data_in,
    output logic             ack,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [HDR_W-1:0] tx_hdr,
    output logic [DW_W-1:0]  tx_data
);
    ctrl_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (req) begin
                    if (msi_on) begin
                        d.st   = ST_SEND;
                        d.hdr  = hdr_in;
                        d.data = data_in;
                    end else begin
                        d.st = ST_DONE;
                    end
                end
            end
            ST_SEND: if (tx_ready) d.st = ST_DONE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_IDLE, hdr: '0, data: '0};
        else        q <= d;
    end

    assign tx_valid = (q.st == ST_SEND);
    assign ack      = (q.st == ST_DONE);
    assign tx_hdr   = q.hdr;
    assign tx_data  = q.data;

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_hdr) && $stable(tx_data));
    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    assert_ack_after_hs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> ack && !tx_valid);
    assert_drop_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid && !ack && req && !msi_on |=> ack && !tx_valid);
endmodule

// File: rtl/pcie_irq_gen.sv
module pcie_irq_gen
    import irq_gen_pkg::*;
#(
    parameter int TC_W   = 3,
    parameter int VEC_W  = 5,
    parameter int MSG_W  = 16,
    parameter int RID_W  = 16,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_msi_on,
    input  logic              cfg_legacy_mask,
    input  logic [CTL_W-1:0]  cfg_msi_ctrl,
    input  logic [ADDR_W-1:0] cfg_msi_addr,
    input  logic [MSG_W-1:0]  cfg_msi_msgdata,
    input  logic [RID_W-1:0]  cfg_bdf,
    input  logic              leg_irq,
    output logic              leg_assert_msg,
    output logic              leg_deassert_msg,
    input  logic              irq_req,
    input  logic [TC_W-1:0]   irq_tc,
    input  logic [VEC_W-1:0]  irq_vec,
    output logic              irq_ack,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [HDR_W-1:0]  tx_hdr,
    output logic [DW_W-1:0]   tx_data
);
    logic [HDR_W-1:0] fmt_hdr;
    logic [DW_W-1:0]  fmt_data;

    irq_legacy_track u_leg (
        .clk         (clk),
        .rst_n       (rst_n),
        .msi_on      (cfg_msi_on),
        .legacy_mask (cfg_legacy_mask),
        .lvl_in      (leg_irq),
        .asrt_o      (leg_assert_msg),
        .deasrt_o    (leg_deassert_msg)
    );

    irq_msi_fmt #(
        .TC_W(TC_W), .VEC_W(VEC_W), .MSG_W(MSG_W), .RID_W(RID_W), .ADDR_W(ADDR_W)
    ) u_fmt (
        .ctl  (cfg_msi_ctrl),
        .addr (cfg_msi_addr),
        .msg  (cfg_msi_msgdata),
        .rid  (cfg_bdf),
        .tc   (irq_tc),
        .vec  (irq_vec),
        .hdr  (fmt_hdr),
        .data (fmt_data)
    );

    irq_msi_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .msi_on   (cfg_msi_on),
        .req      (irq_req),
        .hdr_in   (fmt_hdr),
        .data_in  (fmt_data),
        .ack      (irq_ack),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_hdr   (tx_hdr),
        .tx_data  (tx_data)
    );
endmodule

// File: tb/sim_pcie_irq_gen.sv
`timescale 1ns/1ps
module sim_pcie_irq_gen;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         cfg_msi_on = 0;
    logic         cfg_legacy_mask = 0;
    logic [15:0]  cfg_msi_ctrl = '0;
    logic [63:0]  cfg_msi_addr = 64'h0000_0012_FEE0_1007;
    logic [15:0]  cfg_msi_msgdata = '0;
    logic [15:0]  cfg_bdf = 16'h0A38;
    logic         leg_irq = 0;
    logic         leg_assert_msg, leg_deassert_msg;
    logic         irq_req = 0;
    logic [2:0]   irq_tc = '0;
    logic [4:0]   irq_vec = '0;
    logic         irq_ack;
    logic         tx_valid;
    logic         tx_ready = 0;
    logic [127:0] tx_hdr;
    logic [31:0]  tx_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pcie_irq_gen u0 (.*);

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] want_hdr(input bit wide, input logic [2:0] tc);
        logic [31:0] d0, d1, d2, d3, lo;
        lo = {cfg_msi_addr[31:2], 2'b00};
        d0 = {(wide ? 3'b011 : 3'b010), 5'd0, 1'b0, tc, 10'd0, 10'd1};
        d1 = {cfg_bdf, 8'h00, 4'h0, 4'hF};
        d2 = wide ? cfg_msi_addr[63:32] : lo;
        d3 = wide ? lo : 32'h0;
        return {d3, d2, d1, d0};
    endfunction

    task automatic t_reset();
        chk("R1 tx_valid", 128'(tx_valid), 0);
        chk("R1 irq_ack", 128'(irq_ack), 0);
        chk("R1 legacy pulses", 128'({leg_assert_msg, leg_deassert_msg}), 0);
    endtask

    task automatic t_legacy_basic();
        leg_irq = 1;
        @(negedge clk);
        chk("R2 assert pulse", 128'({leg_assert_msg, leg_deassert_msg}), 128'(2'b10));
        @(negedge clk);
        chk("R2 assert one cycle", 128'({leg_assert_msg, leg_deassert_msg}), 0);
        leg_irq = 0;
        @(negedge clk);
        chk("R2 deassert pulse", 128'({leg_assert_msg, leg_deassert_msg}), 128'(2'b01));
        @(negedge clk);
        chk("R2 deassert one cycle", 128'({leg_assert_msg, leg_deassert_msg}), 0);
    endtask

    task automatic t_legacy_mask();
        cfg_legacy_mask = 1;
        leg_irq = 1;
        @(negedge clk);
        chk("R3 masked no assert", 128'(leg_assert_msg), 0);
        @(negedge clk);
        chk("R3 masked still quiet", 128'(leg_assert_msg), 0);
        cfg_legacy_mask = 0;
        @(negedge clk);
        chk("R3 unmask asserts", 128'({leg_assert_msg, leg_deassert_msg}), 128'(2'b10));
        cfg_legacy_mask = 1;
        @(negedge clk);
        chk("R3 mask deasserts", 128'({leg_assert_msg, leg_deassert_msg}), 128'(2'b01));
        leg_irq = 0;
        cfg_legacy_mask = 0;
        @(negedge clk);
        chk("R3 idle after", 128'({leg_assert_msg, leg_deassert_msg}), 0);
    endtask

    task automatic t_mode_switch();
        leg_irq = 1;
        @(negedge clk);
        chk("R2 level up before switch", 128'(leg_assert_msg), 1);
        cfg_msi_on = 1;
        @(negedge clk);
        chk("R4 MSI on deasserts", 128'({leg_assert_msg, leg_deassert_msg}), 128'(2'b01));
        cfg_legacy_mask = 1;
        leg_irq = 0;
        @(negedge clk);
        cfg_legacy_mask = 0;
        leg_irq = 1;
        @(negedge clk);
        chk("R4 overlap no assert", 128'(leg_assert_msg), 0);
        @(negedge clk);
        chk("R4 MSI priority", 128'({leg_assert_msg, leg_deassert_msg}), 0);
        leg_irq = 0;
        cfg_legacy_mask = 1;
        @(negedge clk);
    endtask

    task automatic t_msi(input logic [15:0] ctl, input logic [15:0] msg, input logic [2:0] tc,
                         input logic [4:0] vec, input int waitn, input logic [31:0] exp_d);
        logic [127:0] eh;
        cfg_msi_ctrl = ctl;
        cfg_msi_msgdata = msg;
        irq_tc = tc;
        irq_vec = vec;
        irq_req = 1;
        eh = want_hdr(ctl[7], tc);
        @(negedge clk);
        chk("R5 valid rises", 128'(tx_valid), 1);
        chk("R6 header", tx_hdr, eh);
        chk("R7 data", 128'(tx_data), 128'(exp_d));
        for (int i = 0; i < waitn; i++) begin
            irq_tc = ~tc;
            irq_vec = ~vec;
            @(negedge clk);
            chk("R5 valid held", 128'(tx_valid), 1);
            chk("R10 header unchanged", tx_hdr, eh);
            chk("R10 data unchanged", 128'(tx_data), 128'(exp_d));
            chk("R8 no early ack", 128'(irq_ack), 0);
        end
        tx_ready = 1;
        @(negedge clk);
        tx_ready = 0;
        chk("R8 ack after handshake", 128'(irq_ack), 1);
        chk("R5 valid drops", 128'(tx_valid), 0);
        irq_req = 0;
        @(negedge clk);
        chk("R8 ack one cycle", 128'(irq_ack), 0);
        chk("R8 no second TLP", 128'(tx_valid), 0);
    endtask

    task automatic t_msi_off();
        cfg_msi_on = 0;
        irq_req = 1;
        @(negedge clk);
        chk("R9 ack without MSI", 128'(irq_ack), 1);
        chk("R9 no TLP", 128'(tx_valid), 0);
        irq_req = 0;
        @(negedge clk);
        chk("R9 quiet after", 128'({irq_ack, tx_valid}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_legacy_basic();
        t_legacy_mask();
        t_mode_switch();
        t_msi(16'h0030, 16'h1230, 3'd5, 5'h1D, 3, 32'h0000_1235);
        t_msi(16'h0080, 16'h4567, 3'd0, 5'h1F, 0, 32'h0000_4567);
        t_msi(16'h00D0, 16'h8AA0, 3'd7, 5'h0B, 1, 32'h0000_8AAB);
        t_msi(16'h0010, 16'h5552, 3'd2, 5'h03, 0, 32'h0000_5553);
        t_msi(16'h00F0, 16'h0000, 3'd4, 5'h16, 2, 32'h0000_0016);
        t_msi_off();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule